// File: doc/BRIEF.md
# Dual-Channel Transmit Staging Buffer

This block holds outgoing frames for a transmitter in two separate byte queues. A host reaches it through a simple write-only register port. A channel-steering register decides which queue receives each 32-bit data write. Each word is split into four bytes and queued lowest byte first. The host then sets a frame length for that channel and issues a start command. The block reads the chosen number of bytes out of that queue and sends them on a byte stream, with a marker on the final byte. When the final byte is accepted, the block empties that queue, sets its length back to zero and latches a per-channel completion flag. A maskable interrupt line reports these flags.

A single stream engine serves both queues, so only one frame is in flight at a time. The output stream uses valid/ready handshaking:
- `m_valid` stays high from the first byte to the last byte of a frame.
- While `m_valid` is high and `m_ready` is low, `m_data`, `m_last` and `m_chan` hold their values.
- A byte moves only in a cycle where both `m_valid` and `m_ready` are high.
- The consumer may hold `m_ready` low for any number of cycles.

Register map. Writes take effect on the clock edge where `reg_wr` is high.

| Address | Function |
|---|---|
| 0 | Global control. Bit 0 is transmit enable. |
| 1 | Channel select. |
| 2 | Data word. |
| 4 + c | Frame length for channel c. |
| 8 + c | Start command for channel c. The start bit is bit 0. |
| 12 | Interrupt mask. Bit c enables channel c. |
| 13 | Completion status, write-one-to-clear. Bit c belongs to channel c. |

Top module: `stg_tx_stage`

## Requirements
- R1: A write to address 2 puts its four bytes into the selected queue, bits 7:0 first and bits 31:24 last. The bytes later leave on `m_data` in that same order.
- R2: A data write is dropped completely if the selected queue has fewer than 4 free bytes. The queue then holds exactly the bytes it held before the write.
- R3: A channel-select write with value 0 or 1 selects that channel. Any other value selects channel 0.
- R4: A length write larger than the queue capacity `DEPTH` is stored as `DEPTH`.
- R5: A start write acts only when bit 0 of the written value is 1 and the transmit-enable bit (address 0, bit 0) is set. Otherwise it has no effect, and the queued data stays in place for a later start.
- R6: At start, the frame length is the smaller of the stored length and the bytes queued on that channel. If this value is zero, nothing is sent and no status bit is set.
- R7: When the last byte of a frame is accepted, the block does three things:
  - It empties that channel's queue.
  - It sets that channel's stored length to 0.
  - It sets status bit c, which is visible on `irq_stat` from the next cycle.
- R8: `irq` is high exactly when some status bit and its mask bit are both 1. A status write clears only the bits written as 1. A status bit never clears without such a write.
- R9: `m_valid` stays high until the byte is accepted. While `m_valid` is high and `m_ready` is low, `m_data`, `m_last` and `m_chan` do not change. `m_last` is high only on the final byte.
- R10: A start write that arrives while a frame is being sent is ignored. This holds for either channel.
- R11: `m_valid` rises in the cycle after an accepted start write. `m_chan` gives the channel of the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Register write data |
| m_valid | output | 1 | Stream byte valid |
| m_ready | input | 1 | Stream consumer ready |
| m_data | output | 8 | Stream byte |
| m_last | output | 1 | Final byte of the frame |
| m_chan | output | 1 | Channel the frame comes from |
| irq_stat | output | 2 | Completion status bits |
| irq | output | 1 | Masked interrupt request |

## Verification
The assertions check the following on every cycle:
- The stream holds steady under back-pressure, and the channel stays fixed for the whole frame.
- Each frame starts only one cycle after an enabled start write.
- Completion sets the matching status bit.
- A status bit clears only after a write-one to address 13.

The bench scenarios show what per-cycle properties cannot see:
- Byte order and content.
- The two length clamps.
- A dropped overflow word.
- Start writes that were ignored because of a zero length or a busy engine.
- The stored length reset to zero after a frame.

// File: rtl/stg_pkg.sv
package stg_pkg;
  localparam int NCH = 2;
  localparam int CHW = 1;
  localparam logic [3:0] ADDR_CTRL  = 4'd0;
  localparam logic [3:0] ADDR_CHSEL = 4'd1;
  localparam logic [3:0] ADDR_DATA  = 4'd2;
  localparam logic [3:0] ADDR_LEN0  = 4'd4;
  localparam logic [3:0] ADDR_GO0   = 4'd8;
  localparam logic [3:0] ADDR_MASK  = 4'd12;
  localparam logic [3:0] ADDR_STAT  = 4'd13;
  typedef enum logic {ENG_IDLE, ENG_SEND} eng_state_e;
endpackage

// File: rtl/stg_byte_fifo.sv
module stg_byte_fifo #(
  parameter int DEPTH = 2048,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [31:0]   push_word,
  input  logic          pop,
  input  logic          clr,
  output logic [7:0]    rd_byte,
  output logic [CW-1:0] count
);
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          push_ok;

  // room for a whole word, otherwise the word is dropped
  assign push_ok = push && !clr && (count <= CW'(DEPTH - 4));
  assign rd_byte = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) begin
      for (int i = 0; i < 4; i++) mem[wr_ptr + AW'(i)] <= push_word[8*i +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + AW'(4);
      if (pop)     rd_ptr <= rd_ptr + AW'(1);
      count <= count + (push_ok ? CW'(4) : CW'(0)) - (pop ? CW'(1) : CW'(0));
    end
  end
endmodule

// File: rtl/stg_stream_engine.sv
module stg_stream_engine
  import stg_pkg::*;
#(
  parameter int DEPTH = 2048,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NCH-1:0]           start_req,
  input  logic [NCH-1:0][CW-1:0]   len_q,
  input  logic [NCH-1:0][CW-1:0]   fill_q,
  input  logic                     m_ready,
  output logic                     m_valid,
  output logic                     m_last,
  output logic [CHW-1:0]           m_chan,
  output logic                     busy,
  output logic [NCH-1:0]           pop,
  output logic [NCH-1:0]           done
);
  eng_state_e    state;
  logic [CW-1:0] remain;
  logic [CHW-1:0] ch_q, pick;
  logic          any_req;
  logic [CW-1:0] amount;

  always_comb begin
    pick    = '0;
    any_req = 1'b0;
    for (int c = 0; c < NCH; c++) begin
      if (start_req[c] && !any_req) begin
        pick    = CHW'(c);
        any_req = 1'b1;
      end
    end
    amount = (len_q[pick] < fill_q[pick]) ? len_q[pick] : fill_q[pick];
  end

  assign busy    = (state == ENG_SEND);
  assign m_valid = busy;
  assign m_last  = busy && (remain == CW'(1));
  assign m_chan  = ch_q;

  always_comb begin
    pop  = '0;
    done = '0;
    pop[ch_q]  = m_valid && m_ready;
    done[ch_q] = m_valid && m_ready && m_last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ENG_IDLE;
      remain <= '0;
      ch_q   <= '0;
    end else begin
      case (state)
        ENG_IDLE: if (any_req && amount != '0) begin
          state  <= ENG_SEND;
          ch_q   <= pick;
          remain <= amount;
        end
        ENG_SEND: if (m_ready) begin
          remain <= remain - CW'(1);
          if (remain == CW'(1)) state <= ENG_IDLE;
        end
        default: state <= ENG_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/stg_irq_ctrl.sv
module stg_irq_ctrl
  import stg_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] set,
  input  logic           mask_wr,
  input  logic           stat_wr,
  input  logic [NCH-1:0] wbits,
  output logic [NCH-1:0] stat,
  output logic           irq
);
  logic [NCH-1:0] mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat <= '0;
      mask <= '0;
    end else begin
      if (mask_wr) mask <= wbits;
      stat <= (stat & ~(stat_wr ? wbits : '0)) | set;
    end
  end

  assign irq = |(stat & mask);
endmodule

// File: rtl/stg_tx_stage.sv
module stg_tx_stage
  import stg_pkg::*;
#(
  parameter int DEPTH = 2048
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_wr,
  input  logic [3:0]     reg_addr,
  input  logic [31:0]    reg_wdata,
  output logic           m_valid,
  input  logic           m_ready,
  output logic [7:0]     m_data,
  output logic           m_last,
  output logic [CHW-1:0] m_chan,
  output logic [NCH-1:0] irq_stat,
  output logic           irq
);
  localparam int CW = $clog2(DEPTH) + 1;

  logic                   tx_en_q;
  logic [CHW-1:0]         sel_q;
  logic [NCH-1:0][CW-1:0] len_q, fill_q;
  logic [NCH-1:0]         start_req, pop, done;
  logic [7:0]             rd_byte [NCH];
  logic                   busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_en_q <= 1'b0;
      sel_q   <= '0;
    end else if (reg_wr) begin
      if (reg_addr == ADDR_CTRL)  tx_en_q <= reg_wdata[0];
      if (reg_addr == ADDR_CHSEL) sel_q <= (reg_wdata < NCH) ? CHW'(reg_wdata) : '0;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic len_wr, push;
    assign len_wr = reg_wr && (reg_addr == 4'(ADDR_LEN0 + c));
    assign push   = reg_wr && (reg_addr == ADDR_DATA) && (sel_q == CHW'(c));
    assign start_req[c] = reg_wr && (reg_addr == 4'(ADDR_GO0 + c)) &&
                          reg_wdata[0] && tx_en_q && !busy;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      len_q[c] <= '0;
      else if (done[c]) len_q[c] <= '0;
      else if (len_wr) len_q[c] <= (reg_wdata > DEPTH) ? CW'(DEPTH) : CW'(reg_wdata);
    end

    stg_byte_fifo #(.DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push(push), .push_word(reg_wdata),
      .pop(pop[c]), .clr(done[c]), .rd_byte(rd_byte[c]), .count(fill_q[c])
    );
  end

  stg_stream_engine #(.DEPTH(DEPTH)) u_eng (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .len_q(len_q),
    .fill_q(fill_q), .m_ready(m_ready), .m_valid(m_valid), .m_last(m_last),
    .m_chan(m_chan), .busy(busy), .pop(pop), .done(done)
  );

  assign m_data = rd_byte[m_chan];

  stg_irq_ctrl u_irq (
    .clk(clk), .rst_n(rst_n), .set(done),
    .mask_wr(reg_wr && reg_addr == ADDR_MASK),
    .stat_wr(reg_wr && reg_addr == ADDR_STAT),
    .wbits(reg_wdata[NCH-1:0]), .stat(irq_stat), .irq(irq)
  );
endmodule

// File: rtl/stg_tx_stage_chk.sv
module stg_tx_stage_chk
  import stg_pkg::*;
(
  input logic           clk,
  input logic           rst_n,
  input logic           reg_wr,
  input logic [3:0]     reg_addr,
  input logic [31:0]    reg_wdata,
  input logic           tx_en,
  input logic           m_valid,
  input logic           m_ready,
  input logic [7:0]     m_data,
  input logic           m_last,
  input logic [CHW-1:0] m_chan,
  input logic [NCH-1:0] irq_stat
);
  // R9
  stream_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_data) && $stable(m_last) && $stable(m_chan));

  // R10
  chan_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !(m_ready && m_last) |=> m_valid && $stable(m_chan));

  // R5
  start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(m_valid) |-> $past(reg_wr && reg_wdata[0] && tx_en &&
                             (reg_addr == ADDR_GO0 || reg_addr == 4'(ADDR_GO0 + 1))));

  // R7
  done_set0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && m_ready && m_last && m_chan == 1'b0 |=> irq_stat[0]);

  // R7
  done_set1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && m_ready && m_last && m_chan == 1'b1 |=> irq_stat[1]);

  // R8
  stat_clr0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_stat[0]) |-> $past(reg_wr && reg_addr == ADDR_STAT && reg_wdata[0]));

  // R8
  stat_clr1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_stat[1]) |-> $past(reg_wr && reg_addr == ADDR_STAT && reg_wdata[1]));
endmodule

bind stg_tx_stage stg_tx_stage_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .tx_en(tx_en_q), .m_valid(m_valid), .m_ready(m_ready),
  .m_data(m_data), .m_last(m_last), .m_chan(m_chan), .irq_stat(irq_stat)
);

// File: tb/sim_stg_tx_stage.sv
module sim_stg_tx_stage;
  localparam int PERIOD = 10;
  localparam int DEPTH  = 64;

  typedef struct packed {
    logic [31:0] sel;
    logic [31:0] nwords;
    logic [31:0] seed;
    logic [31:0] len;
    logic [31:0] exp_n;
    logic [31:0] exp_ch;
    logic [31:0] mode;
  } vec_t;

  localparam vec_t VEC [5] = '{
    '{32'd0, 32'd3,  32'h11223344, 32'd12,   32'd12, 32'd0, 32'd0},
    '{32'd1, 32'd5,  32'hA0B1C2D3, 32'd7,    32'd7,  32'd1, 32'd1},
    '{32'd7, 32'd2,  32'h01020304, 32'd8,    32'd8,  32'd0, 32'd1},
    '{32'd1, 32'd2,  32'hCAFE0000, 32'd100,  32'd8,  32'd1, 32'd0},
    '{32'd0, 32'd17, 32'h10000000, 32'd1000, 32'd64, 32'd0, 32'd1}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic m_valid, m_ready = 1'b1, m_last, irq;
  logic [7:0] m_data;
  logic [0:0] m_chan;
  logic [1:0] irq_stat;

  int checks = 0, fails = 0;
  logic [7:0] got [0:127];
  int got_ch;
  int last_errs;

  always #(PERIOD/2) clk = ~clk;

  stg_tx_stage #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .m_valid(m_valid), .m_ready(m_ready),
    .m_data(m_data), .m_last(m_last), .m_chan(m_chan),
    .irq_stat(irq_stat), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  function automatic logic [31:0] wval(input logic [31:0] seed, input int i);
    return seed ^ (i * 32'h01030507);
  endfunction

  // collect one frame; mode 1 throttles ready
  task automatic collect(input int mode, output int n);
    logic [7:0] held;
    bit was_stalled;
    n = 0; last_errs = 0; got_ch = -1; was_stalled = 0; held = '0;
    for (int k = 0; k < 2000; k++) begin
      m_ready = (mode == 0) ? 1'b1 : ((k % 3) != 1);
      #1;
      if (was_stalled && m_valid && m_data != held) last_errs++;
      was_stalled = 0;
      if (m_valid && !m_ready) begin was_stalled = 1; held = m_data; end
      if (m_valid && m_ready) begin
        if (n < 128) got[n] = m_data;
        got_ch = int'(m_chan);
        n++;
        if (m_last) begin
          @(negedge clk);
          m_ready = 1'b1;
          return;
        end
      end else if (!m_valid && n == 0 && k > 3) begin
        m_ready = 1'b1;
        return;
      end
      @(negedge clk);
    end
    m_ready = 1'b1;
  endtask

  task automatic quiet(input int cyc, output bit saw);
    saw = 0;
    for (int k = 0; k < cyc; k++) begin
      @(negedge clk);
      if (m_valid) saw = 1;
    end
  endtask

  initial begin
    #(PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n;
    bit saw;
    repeat (3) @(negedge clk);
    // reset state
    chk(m_valid == 1'b0, "R9 reset valid", int'(m_valid), 0);
    chk(irq_stat == 2'b00, "R7 reset status", int'(irq_stat), 0);
    chk(irq == 1'b0, "R8 reset irq", int'(irq), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R5: start without enable is ignored, data stays queued
    wr(4'd1, 0);
    wr(4'd2, 32'h44332211);
    wr(4'd2, 32'h88776655);
    wr(4'd4, 8);
    wr(4'd8, 1);
    quiet(5, saw);
    chk(!saw, "R5 start while disabled", int'(saw), 0);
    wr(4'd0, 1);
    wr(4'd8, 0);
    quiet(4, saw);
    chk(!saw, "R5 start bit clear", int'(saw), 0);
    wr(4'd8, 1);
    collect(0, n);
    chk(n == 8, "R5 frame after enable", n, 8);
    chk(got[0] == 8'h11 && got[7] == 8'h88, "R1 byte order", int'(got[7]), 8'h88);
    wr(4'd13, 3);

    // table walk
    foreach (VEC[v]) begin
      int errs;
      wr(4'd1, VEC[v].sel);
      for (int i = 0; i < int'(VEC[v].nwords); i++) wr(4'd2, wval(VEC[v].seed, i));
      wr(4'(4 + VEC[v].exp_ch), VEC[v].len);
      wr(4'(8 + VEC[v].exp_ch), 1);
      collect(int'(VEC[v].mode), n);
      chk(n == int'(VEC[v].exp_n), "R6 R4 R2 sent length", n, int'(VEC[v].exp_n));
      errs = 0;
      for (int j = 0; j < n && j < 128; j++) begin
        logic [31:0] w;
        w = wval(VEC[v].seed, j / 4);
        if (got[j] != w[8*(j%4) +: 8]) errs++;
      end
      chk(errs == 0, "R1 R2 byte content", errs, 0);
      chk(last_errs == 0, "R9 hold under stall", last_errs, 0);
      chk(got_ch == int'(VEC[v].exp_ch), "R3 R11 frame channel", got_ch, int'(VEC[v].exp_ch));
      chk(irq_stat[VEC[v].exp_ch[0]] == 1'b1, "R7 status set", int'(irq_stat), 1);
      wr(4'd13, 3);
      chk(irq_stat == 2'b00, "R8 status cleared", int'(irq_stat), 0);
    end

    // R6: zero length with data, and length with empty queue
    wr(4'd1, 1);
    wr(4'd2, 32'hDEADBEEF);
    wr(4'd5, 0);
    wr(4'd9, 1);
    quiet(5, saw);
    chk(!saw && irq_stat == 2'b00, "R6 zero length", int'(saw), 0);
    wr(4'd4, 8);
    wr(4'd8, 1);
    quiet(5, saw);
    chk(!saw && irq_stat == 2'b00, "R6 empty queue", int'(saw), 0);
    wr(4'd5, 4);
    wr(4'd9, 1);
    collect(0, n);
    chk(n == 4 && got[0] == 8'hEF, "R6 pending data sent", n, 4);
    wr(4'd13, 3);

    // R7: length back to zero after a frame
    wr(4'd2, 32'h0A0B0C0D);
    wr(4'd9, 1);
    quiet(5, saw);
    chk(!saw, "R7 length reset", int'(saw), 0);
    wr(4'd5, 4);
    wr(4'd9, 1);
    collect(0, n);
    chk(n == 4 && got[3] == 8'h0A, "R7 queue emptied", int'(got[3]), 8'h0A);
    wr(4'd13, 3);

    // R10: start on either channel while busy is ignored
    wr(4'd1, 0);
    for (int i = 0; i < 3; i++) wr(4'd2, 32'h50 + i);
    wr(4'd4, 12);
    wr(4'd1, 1);
    wr(4'd2, 32'h77);
    wr(4'd5, 4);
    m_ready = 1'b0;
    wr(4'd8, 1);
    wr(4'd9, 1);
    collect(0, n);
    chk(n == 12 && got_ch == 0, "R10 first frame", n, 12);
    quiet(5, saw);
    chk(!saw && irq_stat == 2'b01, "R10 busy start ignored", int'(irq_stat), 1);
    wr(4'd9, 1);
    collect(0, n);
    chk(n == 4 && got_ch == 1 && got[0] == 8'h77, "R10 later start", n, 4);

    // R8: masking and selective clear
    chk(irq_stat == 2'b11 && irq == 1'b0, "R8 masked off", int'(irq), 0);
    wr(4'd12, 2);
    chk(irq == 1'b1, "R8 mask enables", int'(irq), 1);
    wr(4'd13, 1);
    chk(irq_stat == 2'b10 && irq == 1'b1, "R8 clear one bit", int'(irq_stat), 2);
    wr(4'd13, 2);
    chk(irq_stat == 2'b00 && irq == 1'b0, "R8 clear other bit", int'(irq_stat), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule